// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block brings up a device's identity and bus configuration after a reset. It first reads byte 0 of an external serial EEPROM through a simple byte-read port. If that byte is the signature 0xA5, the loader treats the EEPROM as programmed. It copies every byte of the image into an internal 512-byte SRAM and fills the configuration registers from fixed offsets in that image. If the byte is anything else, or the EEPROM never answers, the loader stops at once and the registers take built-in default values.

A full load starts by itself when the block reset `rst_n` is released. Power-on, pin and soft resets all arrive through that reset. A one-cycle `usb_rst` pulse while idle starts a shorter flow that refreshes only the MAC address. The disconnect output to the USB PHY stays high for as long as any load is running. A descriptor consumer reads the SRAM through a valid/ready request port. The SRAM does not accept requests while a load is running.

EEPROM port rules: `ee_req` rises with `ee_addr` and stays high with a stable address until the cycle in which `ee_ack` is sampled high. `ee_data` is taken in that same cycle. Only one read is ever outstanding. SRAM port rules: a request transfers when `rd_valid` and `rd_ready` are both high at a clock edge. The byte appears on `rd_data` with `rd_data_valid` high one cycle later. The response cannot be stalled.

Top module: `nvcfg_loader`

## Requirements
- R1: While `rst_n` is low, `phy_disconnect` is 1 and `rd_ready` is 0. After release, the first EEPROM read is at address 0.
- R2: Each EEPROM read holds `ee_req` and a stable `ee_addr` until `ee_ack`. Successive reads of one load use addresses 0, 1, 2, … with no gaps.
- R3: When byte 0 equals 0xA5, a full load reads all 512 addresses, 0 to 511. It stores each byte in the SRAM at the same address and ends with `image_valid` = 1.
- R4: The fields are loaded from fixed image byte offsets. `mac_addr` comes from bytes 1..6, with byte 1 as the least significant byte. `fs_poll` comes from byte 7, `hs_poll` from byte 8, `cfg_flags` from byte 9 and `max_power` from byte 10. `vendor_id` comes from bytes 11..12 and `product_id` from bytes 13..14, each with the low byte first.
- R5: When byte 0 is not 0xA5, a full load performs that one read and ends with `image_valid` = 0. The defaults are applied: MAC 0xFFFFFFFFFFFF, full-speed poll 0x01, high-speed poll 0x04, maximum power 0xFA, vendor 0x0424 and product 0x9730.
- R6: On the default path, `cfg_flags` = 0x04 with bit 1 equal to `wake_strap`. On the image path, `cfg_flags` equals byte 9 unchanged.
- R7: A `usb_rst` pulse while idle with a valid signature reads addresses 0..6 only. It updates `mac_addr` only. All other fields, `image_valid` and the SRAM contents are unchanged.
- R8: A `usb_rst` load whose signature is not 0xA5 leaves `mac_addr` at its previous value.
- R9: `phy_disconnect` is 1 from the start of a load until it ends and 0 afterwards. `load_done` is a single-cycle pulse in the first cycle with `phy_disconnect` low.
- R10: If `ee_ack` does not arrive within `timeout_cycles` cycles of a request, the load ends. A full load then applies the defaults with `image_valid` = 0. A USB-reset load then changes nothing.
- R11: `rd_ready` is 0 while a load runs and 1 when idle. An accepted SRAM request returns its byte with `rd_data_valid` one cycle later.
- R12: A `usb_rst` pulse during a running load is ignored. The running load continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release starts a full load |
| usb_rst | input | 1 | One-cycle pulse requesting a MAC-only reload |
| wake_strap | input | 1 | Remote-wakeup strap, sets default flag bit 1 |
| timeout_cycles | input | 16 | Cycles to wait for each EEPROM acknowledge |
| ee_req | output | 1 | EEPROM byte-read request |
| ee_addr | output | 9 | EEPROM byte address |
| ee_ack | input | 1 | EEPROM read acknowledge |
| ee_data | input | 8 | EEPROM read byte, valid with `ee_ack` |
| rd_valid | input | 1 | SRAM read request valid |
| rd_ready | output | 1 | SRAM accepts requests (idle) |
| rd_addr | input | 9 | SRAM read address |
| rd_data_valid | output | 1 | SRAM read response valid |
| rd_data | output | 8 | SRAM read response byte |
| mac_addr | output | 48 | MAC address |
| fs_poll | output | 8 | Full-speed polling interval |
| hs_poll | output | 8 | High-speed polling interval |
| cfg_flags | output | 8 | Configuration flags |
| max_power | output | 8 | Maximum power |
| vendor_id | output | 16 | Vendor ID |
| product_id | output | 16 | Product ID |
| image_valid | output | 1 | Last full load used a valid image |
| load_done | output | 1 | One-cycle end-of-load pulse |
| phy_disconnect | output | 1 | Holds the USB PHY disconnected during loads |

## Verification
Full loads are run with random images behind a valid signature and with random non-signature bytes. Comparing the two shows whether the decision rests on byte 0 alone and whether the strap touches only the default flags. The EEPROM answers with random latency of 0 to 3 cycles, which tells apart a loader that truly waits for the acknowledge from one that assumes fixed timing. MAC-only reloads use a second image whose every field differs from the loaded one, so any leak into other fields or into the SRAM shows. A silent EEPROM, together with `usb_rst` pulses and SRAM requests injected mid-load, separates the timeout path and the busy-time blocking from normal completion.

// File: rtl/nvcfg_pkg.sv
package nvcfg_pkg;
  localparam logic [7:0] SIG_BYTE = 8'hA5;

  // image byte offsets decoded by the field registers
  localparam int OFF_MAC  = 1;
  localparam int MAC_LEN  = 6;
  localparam int OFF_FS   = 7;
  localparam int OFF_HS   = 8;
  localparam int OFF_FLG  = 9;
  localparam int OFF_PWR  = 10;
  localparam int OFF_VID  = 11;
  localparam int OFF_PID  = 13;
  localparam int LAST_MAC = OFF_MAC + MAC_LEN - 1;

  localparam logic [47:0] DEF_MAC = 48'hFFFF_FFFF_FFFF;
  localparam logic [7:0]  DEF_FS  = 8'h01;
  localparam logic [7:0]  DEF_HS  = 8'h04;
  localparam logic [7:0]  DEF_FLG = 8'h04;
  localparam int          STRAP_BIT = 1;
  localparam logic [7:0]  DEF_PWR = 8'hFA;
  localparam logic [15:0] DEF_VID = 16'h0424;
  localparam logic [15:0] DEF_PID = 16'h9730;

  typedef struct packed {
    logic [47:0] mac;
    logic [7:0]  fs;
    logic [7:0]  hs;
    logic [7:0]  flg;
    logic [7:0]  pwr;
    logic [15:0] vid;
    logic [15:0] pid;
  } cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_READ} ld_state_e;
endpackage

// File: rtl/nvcfg_seq.sv
module nvcfg_seq
  import nvcfg_pkg::*;
#(
  parameter int IMG_BYTES = 512,
  parameter int TMO_W     = 16,
  localparam int ADDR_W   = $clog2(IMG_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usb_rst,
  input  logic [TMO_W-1:0]  timeout_cycles,
  output logic              ee_req,
  output logic [ADDR_W-1:0] ee_addr,
  input  logic              ee_ack,
  input  logic [7:0]        ee_data,
  output logic              busy,
  output logic              mac_only,
  output logic              byte_vld,
  output logic              apply_def,
  output logic              image_valid,
  output logic              load_done
);
  localparam logic [ADDR_W-1:0] LAST_FULL = ADDR_W'(IMG_BYTES - 1);
  localparam logic [ADDR_W-1:0] LAST_MACA = ADDR_W'(LAST_MAC);

  ld_state_e        state;
  logic             full;
  logic [TMO_W-1:0] wait_cnt;
  logic             take, tmo_hit, sig_bad, at_last, finish, fail;
  logic [ADDR_W-1:0] last_addr;

  assign take      = ee_req & ee_ack;
  assign tmo_hit   = ee_req & ~ee_ack & (wait_cnt >= timeout_cycles);
  assign sig_bad   = take & (ee_addr == '0) & (ee_data != SIG_BYTE);
  assign last_addr = full ? LAST_FULL : LAST_MACA;
  assign at_last   = take & ~sig_bad & (ee_addr == last_addr);
  assign fail      = sig_bad | tmo_hit;
  assign finish    = fail | at_last;

  assign byte_vld  = take & ~sig_bad;
  assign apply_def = fail & full;
  assign mac_only  = ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_ARM;
      full        <= 1'b1;
      ee_req      <= 1'b0;
      ee_addr     <= '0;
      wait_cnt    <= '0;
      busy        <= 1'b1;
      load_done   <= 1'b0;
      image_valid <= 1'b0;
    end else begin
      load_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (usb_rst) begin
            state <= ST_ARM;
            full  <= 1'b0;
            busy  <= 1'b1;
          end
        end
        ST_ARM: begin
          ee_req   <= 1'b1;
          ee_addr  <= '0;
          wait_cnt <= '0;
          state    <= ST_READ;
        end
        ST_READ: begin
          if (finish) begin
            ee_req    <= 1'b0;
            busy      <= 1'b0;
            load_done <= 1'b1;
            state     <= ST_IDLE;
            if (full) image_valid <= ~fail;
          end else if (take) begin
            ee_addr  <= ee_addr + 1'b1;
            wait_cnt <= '0;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: a pending read keeps its address until acknowledged or abandoned
  a_r2_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && !ee_ack |=> !ee_req || $stable(ee_addr));

  // R2: an acknowledged read is followed by the next address or by the end
  a_r2_next_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && ee_ack |=> !ee_req || (ee_addr == $past(ee_addr) + 1'b1));

  // R5: a wrong signature ends the load right after the first read
  a_r5_sig_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && ee_ack && (ee_addr == '0) && (ee_data != SIG_BYTE)
    |=> !ee_req && load_done);

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);

  // R12: a reset pulse while busy does not change the running mode
  a_r12_ignore_usb: assert property (@(posedge clk) disable iff (!rst_n)
    busy && usb_rst && (state == ST_READ) |=> $stable(full));
endmodule

// File: rtl/nvcfg_fields.sv
module nvcfg_fields
  import nvcfg_pkg::*;
#(
  parameter int IMG_BYTES = 512,
  localparam int ADDR_W   = $clog2(IMG_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic              mac_only,
  input  logic              apply_def,
  input  logic              strap,
  output cfg_t              cfg
);
  int a;
  assign a = int'(addr);

  logic [7:0] def_flags;
  always_comb begin
    def_flags = DEF_FLG;
    def_flags[STRAP_BIT] = strap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '{mac: DEF_MAC, fs: DEF_FS, hs: DEF_HS, flg: DEF_FLG,
               pwr: DEF_PWR, vid: DEF_VID, pid: DEF_PID};
    end else if (apply_def) begin
      cfg <= '{mac: DEF_MAC, fs: DEF_FS, hs: DEF_HS, flg: def_flags,
               pwr: DEF_PWR, vid: DEF_VID, pid: DEF_PID};
    end else if (wr) begin
      if (a >= OFF_MAC && a <= LAST_MAC) cfg.mac[8*(a-OFF_MAC) +: 8] <= data;
      if (!mac_only) begin
        if (a == OFF_FS)      cfg.fs       <= data;
        if (a == OFF_HS)      cfg.hs       <= data;
        if (a == OFF_FLG)     cfg.flg      <= data;
        if (a == OFF_PWR)     cfg.pwr      <= data;
        if (a == OFF_VID)     cfg.vid[7:0]  <= data;
        if (a == OFF_VID + 1) cfg.vid[15:8] <= data;
        if (a == OFF_PID)     cfg.pid[7:0]  <= data;
        if (a == OFF_PID + 1) cfg.pid[15:8] <= data;
      end
    end
  end

  // R7: a MAC-only reload never alters the non-MAC fields
  a_r7_mac_only: assert property (@(posedge clk) disable iff (!rst_n)
    mac_only && !apply_def |=> $stable(cfg.fs) && $stable(cfg.hs) &&
    $stable(cfg.flg) && $stable(cfg.pwr) && $stable(cfg.vid) && $stable(cfg.pid));
endmodule

// File: rtl/nvcfg_sram.sv
module nvcfg_sram #(
  parameter int DEPTH   = 512,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              locked,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_data_valid,
  output logic [7:0]        rd_data
);
  logic [7:0] mem [DEPTH];

  assign rd_ready = ~locked;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_valid && rd_ready) rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data_valid <= 1'b0;
    else        rd_data_valid <= rd_valid & rd_ready;
  end

  // R11: a request refused during loading yields no response
  a_r11_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> !rd_data_valid);

  // R11: an accepted request answers on the next cycle
  a_r11_answer: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> rd_data_valid);
endmodule

// File: rtl/nvcfg_loader.sv
module nvcfg_loader
  import nvcfg_pkg::*;
#(
  parameter int IMG_BYTES = 512,
  parameter int TMO_W     = 16,
  localparam int ADDR_W   = $clog2(IMG_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usb_rst,
  input  logic              wake_strap,
  input  logic [TMO_W-1:0]  timeout_cycles,
  output logic              ee_req,
  output logic [ADDR_W-1:0] ee_addr,
  input  logic              ee_ack,
  input  logic [7:0]        ee_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_data_valid,
  output logic [7:0]        rd_data,
  output logic [47:0]       mac_addr,
  output logic [7:0]        fs_poll,
  output logic [7:0]        hs_poll,
  output logic [7:0]        cfg_flags,
  output logic [7:0]        max_power,
  output logic [15:0]       vendor_id,
  output logic [15:0]       product_id,
  output logic              image_valid,
  output logic              load_done,
  output logic              phy_disconnect
);
  logic busy, mac_only, byte_vld, apply_def;
  cfg_t cfg;

  nvcfg_seq #(.IMG_BYTES(IMG_BYTES), .TMO_W(TMO_W)) seq_i (
    .clk, .rst_n, .usb_rst, .timeout_cycles,
    .ee_req, .ee_addr, .ee_ack, .ee_data,
    .busy, .mac_only, .byte_vld, .apply_def, .image_valid, .load_done
  );

  nvcfg_fields #(.IMG_BYTES(IMG_BYTES)) fields_i (
    .clk, .rst_n, .wr(byte_vld), .addr(ee_addr), .data(ee_data),
    .mac_only, .apply_def, .strap(wake_strap), .cfg
  );

  nvcfg_sram #(.DEPTH(IMG_BYTES)) sram_i (
    .clk, .rst_n,
    .wr_en(byte_vld & ~mac_only), .wr_addr(ee_addr), .wr_data(ee_data),
    .locked(busy), .rd_valid, .rd_ready, .rd_addr, .rd_data_valid, .rd_data
  );

  assign phy_disconnect = busy;
  assign mac_addr   = cfg.mac;
  assign fs_poll    = cfg.fs;
  assign hs_poll    = cfg.hs;
  assign cfg_flags  = cfg.flg;
  assign max_power  = cfg.pwr;
  assign vendor_id  = cfg.vid;
  assign product_id = cfg.pid;

  // R9: the PHY is released exactly when a load reports completion
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_disconnect) |-> load_done);
endmodule

// File: tb/nvcfg_loader_tb_top.sv
module nvcfg_loader_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, usb_rst = 1'b0, wake_strap = 1'b0;
  logic [15:0] timeout_cycles = 16'd1000;
  logic        ee_req, ee_ack = 1'b0;
  logic [8:0]  ee_addr;
  logic [7:0]  ee_data = 8'h00;
  logic        rd_valid = 1'b0, rd_ready, rd_data_valid;
  logic [8:0]  rd_addr = '0;
  logic [7:0]  rd_data, fs_poll, hs_poll, cfg_flags, max_power;
  logic [47:0] mac_addr;
  logic [15:0] vendor_id, product_id;
  logic        image_valid, load_done, phy_disconnect;

  nvcfg_loader dut_i (.*);

  int n_tests = 0, n_fail = 0;
  logic [7:0] img [512];
  logic [7:0] sram_ref [512];
  bit mute = 0;
  int reads = 0, exp_next = 0, bad_seq = 0, first_addr = -1, lat = 0;
  int done_cyc = 0;

  // EEPROM model: answers each request after 0..3 idle cycles
  always @(negedge clk) begin
    if (ee_ack) ee_ack = 1'b0;
    else if (ee_req && !mute) begin
      if (lat == 0) begin
        ee_ack  = 1'b1;
        ee_data = img[ee_addr];
        if (reads == 0) first_addr = int'(ee_addr);
        if (int'(ee_addr) != exp_next) bad_seq++;
        exp_next = int'(ee_addr) + 1;
        reads++;
        lat = $urandom % 4;
      end else lat--;
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [47:0] f_mac();
    return {img[6], img[5], img[4], img[3], img[2], img[1]};
  endfunction

  function automatic logic [7:0] f_def_flags(bit s);
    return 8'h04 | (s ? 8'h02 : 8'h00);
  endfunction

  task automatic clear_log();
    reads = 0; exp_next = 0; bad_seq = 0; first_addr = -1;
  endtask

  // waits for load_done; checks disconnect during load and pulse width
  task automatic wait_done(bit probe);
    int cyc = 0;
    int disc_low = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (!load_done && !phy_disconnect) disc_low++;
      if (probe && cyc == 40) begin
        chk("R11", "rd_ready during load", 64'(rd_ready), 64'd0);
        rd_valid = 1'b1; usb_rst = 1'b1;
        @(negedge clk);
        cyc++;
        rd_valid = 1'b0; usb_rst = 1'b0;
        chk("R11", "no response while loading", 64'(rd_data_valid), 64'd0);
      end
    end while (!load_done && cyc < 5000);
    done_cyc = cyc;
    chk("R9", "load completed", 64'(load_done), 64'd1);
    chk("R9", "disconnect high during load", 64'(disc_low), 64'd0);
    chk("R9", "disconnect low at done", 64'(phy_disconnect), 64'd0);
    @(negedge clk);
    chk("R9", "done single pulse", 64'(load_done), 64'd0);
    chk("R11", "ready when idle", 64'(rd_ready), 64'd1);
  endtask

  task automatic fill_img(bit good);
    for (int i = 0; i < 512; i++) img[i] = 8'($urandom);
    if (good) img[0] = 8'hA5;
    else if (img[0] == 8'hA5) img[0] = 8'h00;
  endtask

  task automatic run_full(bit good, bit strap, bit probe);
    fill_img(good);
    wake_strap = strap;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "disconnect in reset", 64'(phy_disconnect), 64'd1);
    chk("R1", "rd_ready in reset", 64'(rd_ready), 64'd0);
    clear_log();
    rst_n = 1'b1;
    wait_done(probe);
    chk("R1", "first read address", 64'(first_addr), 64'd0);
    if (good) begin
      for (int i = 0; i < 512; i++) sram_ref[i] = img[i];
      chk("R3", "reads in full copy", 64'(reads), 64'd512);
      chk("R2", "address order", 64'(bad_seq), 64'd0);
      chk("R3", "image_valid", 64'(image_valid), 64'd1);
      chk("R4", "mac", 64'(mac_addr), 64'(f_mac()));
      chk("R4", "fs_poll", 64'(fs_poll), 64'(img[7]));
      chk("R4", "hs_poll", 64'(hs_poll), 64'(img[8]));
      chk("R6", "flags from image", 64'(cfg_flags), 64'(img[9]));
      chk("R4", "max_power", 64'(max_power), 64'(img[10]));
      chk("R4", "vendor_id", 64'(vendor_id), 64'({img[12], img[11]}));
      chk("R4", "product_id", 64'(product_id), 64'({img[14], img[13]}));
      if (probe) chk("R12", "usb_rst mid-load ignored", 64'(reads), 64'd512);
    end else begin
      chk("R5", "single read", 64'(reads), 64'd1);
      chk("R5", "image_valid", 64'(image_valid), 64'd0);
      chk("R5", "mac default", 64'(mac_addr), 64'hFFFF_FFFF_FFFF);
      chk("R5", "fs default", 64'(fs_poll), 64'h01);
      chk("R5", "hs default", 64'(hs_poll), 64'h04);
      chk("R6", "flags default with strap", 64'(cfg_flags), 64'(f_def_flags(strap)));
      chk("R5", "power default", 64'(max_power), 64'hFA);
      chk("R5", "vendor default", 64'(vendor_id), 64'h0424);
      chk("R5", "product default", 64'(product_id), 64'h9730);
    end
  endtask

  task automatic sram_reads(int n);
    for (int k = 0; k < n; k++) begin
      int a;
      a = (k == 0) ? 511 : (k == 1) ? 0 : int'($urandom % 512);
      rd_valid = 1'b1; rd_addr = 9'(a);
      @(negedge clk);
      rd_valid = 1'b0;
      chk("R11", "rd_data_valid", 64'(rd_data_valid), 64'd1);
      chk("R3", "sram byte", 64'(rd_data), 64'(sram_ref[a]));
    end
  endtask

  task automatic run_usb(bit good);
    logic [47:0] old_mac;
    logic [63:0] old_rest;
    logic old_iv;
    old_mac  = mac_addr;
    old_rest = {fs_poll, hs_poll, cfg_flags, max_power, vendor_id, product_id};
    old_iv   = image_valid;
    for (int i = 0; i < 512; i++) img[i] = ~sram_ref[i];
    img[0] = good ? 8'hA5 : 8'h5A;
    clear_log();
    usb_rst = 1'b1;
    @(negedge clk);
    usb_rst = 1'b0;
    wait_done(1'b0);
    if (mute) begin
      chk("R10", "usb timeout keeps mac", 64'(mac_addr), 64'(old_mac));
      chk("R10", "usb timeout keeps fields", old_rest,
          {fs_poll, hs_poll, cfg_flags, max_power, vendor_id, product_id});
    end else if (good) begin
      chk("R7", "reads in mac reload", 64'(reads), 64'd7);
      chk("R7", "mac reloaded", 64'(mac_addr), 64'(f_mac()));
      chk("R7", "other fields kept", old_rest,
          {fs_poll, hs_poll, cfg_flags, max_power, vendor_id, product_id});
    end else begin
      chk("R8", "single read", 64'(reads), 64'd1);
      chk("R8", "mac retained", 64'(mac_addr), 64'(old_mac));
    end
    chk("R7", "image_valid kept", 64'(image_valid), 64'(old_iv));
    rd_valid = 1'b1; rd_addr = 9'd3;
    @(negedge clk);
    rd_valid = 1'b0;
    chk("R7", "sram untouched", 64'(rd_data), 64'(sram_ref[3]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    run_full(1'b1, 1'b0, 1'b1);
    sram_reads(16);
    run_usb(1'b1);
    run_usb(1'b0);
    mute = 1; timeout_cycles = 16'd20;
    run_usb(1'b1);
    mute = 0; timeout_cycles = 16'd1000;
    run_full(1'b0, 1'b1, 1'b0);
    run_full(1'b0, 1'b0, 1'b0);
    // R10: silent EEPROM on a full load
    mute = 1; timeout_cycles = 16'd20;
    fill_img(1'b1);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    clear_log(); wake_strap = 1'b1;
    rst_n = 1'b1;
    wait_done(1'b0);
    chk("R10", "timeout latency", 64'(done_cyc >= 21 && done_cyc <= 23), 64'd1);
    chk("R10", "no reads", 64'(reads), 64'd0);
    chk("R10", "image_valid", 64'(image_valid), 64'd0);
    chk("R10", "mac default", 64'(mac_addr), 64'hFFFF_FFFF_FFFF);
    chk("R10", "flags default", 64'(cfg_flags), 64'(f_def_flags(1'b1)));
    mute = 0; timeout_cycles = 16'd1000;
    for (int r = 0; r < 4; r++) begin
      run_full(1'b1, 1'(r), 1'b0);
      sram_reads(6);
      run_usb(1'($urandom % 2));
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule